// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This block keeps the stack pointer of a small 8-bit processor. The pointer is 16 bits wide. Only its low seven bits are stored, so it always stays inside a fixed 128-byte window from 0100h to 017Fh. The upper bits come from a fixed base and cannot change. The pointer always names the next free byte. A write (push) uses the current address and then moves the pointer down by one. A read (pop) first moves the pointer up by one and then uses the new address. If a step goes past either end of the window, the pointer wraps silently to the other end. No flag is raised.

Commands arrive on a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The block drops `cmd_ready` while it issues a multi-byte frame. It issues one stack byte per cycle and gives the memory address, a write or read strobe, and a lane code for each byte. The lane code tells the surrounding datapath which register the byte belongs to. A caller that keeps `cmd_valid` high while `cmd_ready` is low is simply held; the command is taken once `cmd_ready` returns. Two commands change the pointer without any memory traffic: reset-stack and load-low-byte.

Top module: `wrap_stack_ptr`

## Requirements
- R1: After reset the pointer reads 017Fh, `cmd_ready` is 1, and `busy`, `mem_wr` and `mem_rd` are 0.
- R2: `sp` and every strobed `mem_addr` always have bits 15..7 equal to 0000_0001_0.
- R3: Push (op 0) gives one write cycle in the cycle after acceptance. The address is the current pointer and the lane is 5 (plain data). The pointer then drops by one.
- R4: Pop (op 1) gives one read cycle at pointer+1 with lane 5. After that cycle the pointer equals the address that was read.
- R5: Wrap: a write at 0100h leaves the pointer at 017Fh. A read from pointer 017Fh uses address 0100h.
- R6: Call (op 2) writes two bytes in two consecutive cycles. The first is lane 0 (PC low) at the pointer. The second is lane 1 (PC high) at pointer-1. The pointer ends 2 lower.
- R7: Interrupt entry (op 4) writes five bytes in lane order 0,1,2,3,4 (PC low, PC high, X, A, CC) at descending addresses. It starts at the pointer, and the pointer ends 5 lower.
- R8: Return (op 3) reads lanes 1,0 and interrupt return (op 5) reads lanes 4,3,2,1,0. Both read at ascending addresses starting at pointer+1, and the pointer ends higher by the frame length.
- R9: Reset-stack (op 6) sets the pointer to 017Fh on its accepting edge, with no strobe.
- R10: Load-low (op 7) sets the pointer to 0100h | (ld_data & 7Fh) on its accepting edge, with no strobe. The high byte stays 01h.
- R11: `cmd_ready` equals not `busy`. After a frame command is accepted, `busy` is high for exactly the frame length in cycles. While `cmd_ready` is low, a presented command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 push … 7 load-low) |
| ld_data | input | 8 | New low byte for load-low |
| mem_addr | output | 16 | Stack byte address |
| mem_wr | output | 1 | Stack byte write strobe |
| mem_rd | output | 1 | Stack byte read strobe |
| mem_lane | output | 3 | Register lane of the current byte |
| busy | output | 1 | Frame in progress |
| sp | output | 16 | Current pointer value |

## Verification
The bench loads all 256 low-byte values to show that bit 7 is always masked off. For each of the 128 start positions, it then runs every frame command and checks the address and lane of each byte against arithmetic. Start positions near either end of the window separate a correct modulo-128 wrap from a carry into the high byte. The paired write and read frames check two things: the lane order is mirrored between them, and each frame returns the pointer to where it began. A reset-stack command presented while an interrupt frame is running must leave the pointer unchanged, which confirms that back-pressure holds the command off.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_INTR = 3'd4,
    OP_IRET = 3'd5,
    OP_RSP  = 3'd6,
    OP_LDLO = 3'd7
  } wsp_op_e;

  localparam int LANE_W = 3;

  typedef enum logic [LANE_W-1:0] {
    LN_PCL  = 3'd0,
    LN_PCH  = 3'd1,
    LN_X    = 3'd2,
    LN_A    = 3'd3,
    LN_CC   = 3'd4,
    LN_DATA = 3'd5
  } wsp_lane_e;

  localparam int CALL_BYTES = 2;
  localparam int INTR_BYTES = 5;
endpackage

// File: rtl/wsp_ptr.sv
module wsp_ptr #(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BASE     = 16'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec,
  input  logic              inc,
  input  logic              reload_top,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0]   WIN_MASK = ADDR_W'((1 << WIN_BITS) - 1);
  localparam logic [ADDR_W-1:0]   BASE_HI  = BASE & ~WIN_MASK;
  localparam logic [WIN_BITS-1:0] ONE      = WIN_BITS'(1);
  localparam logic [WIN_BITS-1:0] TOP_LO   = '1;

  logic [WIN_BITS-1:0] lo_q;
  logic [WIN_BITS-1:0] ld_lo;
  logic [WIN_BITS-1:0] lo_up;

  // Load path: drop bits above the window, or zero-extend a narrow bus.
  generate
    if (DATA_W >= WIN_BITS) begin : g_trunc
      assign ld_lo = ld_data[WIN_BITS-1:0];
    end else begin : g_extend
      assign ld_lo = {{(WIN_BITS-DATA_W){1'b0}}, ld_data};
    end
  endgenerate

  assign lo_up = lo_q + ONE;

  always_ff @(posedge clk) begin
    if (rst || reload_top) begin
      lo_q <= TOP_LO;
    end else if (load) begin
      lo_q <= ld_lo;
    end else if (dec) begin
      lo_q <= lo_q - ONE;
    end else if (inc) begin
      lo_q <= lo_up;
    end
  end

  assign sp      = BASE_HI | ADDR_W'(lo_q);
  assign rd_addr = BASE_HI | ADDR_W'(lo_up);
endmodule

// File: rtl/wsp_frame_seq.sv
module wsp_frame_seq
  import wsp_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  wsp_op_e   op,
  output logic      active,
  output logic      is_write,
  output wsp_lane_e lane
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] len_q;
  logic              single_q;
  logic [STEP_W-1:0] idx;

  function automatic logic [STEP_W-1:0] frame_len(input wsp_op_e o);
    case (o)
      OP_PUSH, OP_POP: frame_len = STEP_W'(1);
      OP_CALL, OP_RET: frame_len = STEP_W'(CALL_BYTES);
      OP_INTR, OP_IRET: frame_len = STEP_W'(INTR_BYTES);
      default: frame_len = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      is_write <= 1'b0;
      single_q <= 1'b0;
      step_q   <= '0;
      len_q    <= '0;
    end else if (start) begin
      active   <= 1'b1;
      step_q   <= '0;
      len_q    <= frame_len(op);
      is_write <= (op == OP_PUSH) || (op == OP_CALL) || (op == OP_INTR);
      single_q <= (op == OP_PUSH) || (op == OP_POP);
    end else if (active) begin
      if (step_q == len_q - ONE) begin
        active <= 1'b0;
      end else begin
        step_q <= step_q + ONE;
      end
    end
  end

  // Write frames go low-PC first; read frames walk the same list backwards.
  assign idx  = is_write ? step_q : (len_q - ONE - step_q);
  assign lane = single_q ? LN_DATA : wsp_lane_e'(idx[LANE_W-1:0]);
endmodule

// File: rtl/wrap_stack_ptr.sv
module wrap_stack_ptr
  import wsp_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BASE     = 16'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [2:0]        mem_lane,
  output logic              busy,
  output logic [ADDR_W-1:0] sp
);
  localparam int STEP_W = $clog2(INTR_BYTES + 1);

  wsp_op_e           op;
  logic              accept;
  logic              start_frame;
  logic              seq_active;
  logic              seq_write;
  wsp_lane_e         seq_lane;
  logic [ADDR_W-1:0] rd_addr;

  assign op          = wsp_op_e'(cmd_op);
  assign accept      = cmd_valid && cmd_ready;
  assign start_frame = accept && (op != OP_RSP) && (op != OP_LDLO);

  wsp_frame_seq #(.STEP_W(STEP_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start_frame),
    .op       (op),
    .active   (seq_active),
    .is_write (seq_write),
    .lane     (seq_lane)
  );

  wsp_ptr #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .DATA_W   (DATA_W),
    .BASE     (BASE)
  ) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .dec        (mem_wr),
    .inc        (mem_rd),
    .reload_top (accept && (op == OP_RSP)),
    .load       (accept && (op == OP_LDLO)),
    .ld_data    (ld_data),
    .sp         (sp),
    .rd_addr    (rd_addr)
  );

  assign busy      = seq_active;
  assign cmd_ready = !seq_active;
  assign mem_wr    = seq_active && seq_write;
  assign mem_rd    = seq_active && !seq_write;
  assign mem_addr  = mem_rd ? rd_addr : sp;
  assign mem_lane  = seq_lane;
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BASE     = 16'h0100
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] ld_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              busy,
  input logic [ADDR_W-1:0] sp
);
  localparam logic [WIN_BITS-1:0] ONE  = WIN_BITS'(1);
  localparam logic [ADDR_W-1:0]   MASK = ADDR_W'((1 << WIN_BITS) - 1);
  localparam logic [ADDR_W-1:0]   TOP  = (BASE & ~MASK) | MASK;

  a_r1_reset_top: assert property (@(posedge clk)
    $past(rst) && !rst |-> (sp == TOP) && !busy);

  a_r2_sp_window: assert property (@(posedge clk) disable iff (rst)
    (sp & ~MASK) == (BASE & ~MASK));

  a_r2_addr_window: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || mem_rd) |-> (mem_addr & ~MASK) == (BASE & ~MASK));

  a_r3_write_at_sp: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_addr == sp);

  a_r3_post_dec: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> sp[WIN_BITS-1:0] == $past(sp[WIN_BITS-1:0]) - ONE);

  a_r4_pre_inc: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> sp == $past(mem_addr));

  a_r11_ready_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_ready == !busy);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, mem_rd}) && (busy == (mem_wr || mem_rd)));

  a_r9_reload_top: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_op == 3'd6 |=> sp == TOP);

  a_r10_load_low: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_op == 3'd7 |=>
      sp[WIN_BITS-1:0] == $past(ld_data[WIN_BITS-1:0]));
endmodule

bind wrap_stack_ptr wsp_checker #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS),
  .DATA_W   (DATA_W),
  .BASE     (BASE)
) u_wsp_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .ld_data   (ld_data),
  .mem_addr  (mem_addr),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .busy      (busy),
  .sp        (sp)
);

// File: tb/test_wrap_stack_ptr.sv
module test_wrap_stack_ptr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  ld_data = 8'd0;
  logic [15:0] mem_addr;
  logic        mem_wr;
  logic        mem_rd;
  logic [2:0]  mem_lane;
  logic        busy;
  logic [15:0] sp;

  int checks = 0;
  int errors = 0;
  int exp_lo = 127;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wrap_stack_ptr i_wrap_stack_ptr (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .ld_data (ld_data), .mem_addr (mem_addr),
    .mem_wr (mem_wr), .mem_rd (mem_rd), .mem_lane (mem_lane),
    .busy (busy), .sp (sp)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_low(int v);
    @(negedge clk);
    chk("R11 ready before load", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = 3'd7; ld_data = v[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_lo = v & 127;
    chk("R10 load low sp", sp, 'h100 | exp_lo);
    chk("R10 no strobe", {mem_wr, mem_rd}, 0);
  endtask

  // Frame commands: op, byte count, write direction, requirement tag.
  task automatic run_frame(int op, int n, bit wr, string req);
    int lo0 = exp_lo;
    @(negedge clk);
    chk("R11 ready before frame", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op[2:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int lo_k  = wr ? ((lo0 - k) & 127) : ((lo0 + 1 + k) & 127);
      int lane  = (n == 1) ? 5 : (wr ? k : n - 1 - k);
      bit wraps = wr ? (lo0 - k < 0) : (lo0 + 1 + k > 127);
      string t  = wraps ? {"R5 wrap ", req} : req;
      chk({t, " write strobe"}, mem_wr, wr);
      chk({t, " read strobe"}, mem_rd, !wr);
      chk({t, " address"}, mem_addr, 'h100 | lo_k);
      chk({t, " lane"}, mem_lane, lane);
      chk("R11 busy in frame", busy, 1);
      @(negedge clk);
    end
    exp_lo = wr ? ((lo0 - n) & 127) : ((lo0 + n) & 127);
    chk("R11 busy after frame", busy, 0);
    chk({req, " final sp"}, sp, 'h100 | exp_lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sp", sp, 'h17F);
    chk("R1 reset ready", cmd_ready, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset strobes", {mem_wr, mem_rd}, 0);

    for (int v = 0; v < 256; v++) begin
      load_low(v);
      chk("R2 high bits", sp >> 7, 2);
    end

    for (int s = 0; s < 128; s++) begin
      load_low(s);
      run_frame(0, 1, 1'b1, "R3 push");
      run_frame(1, 1, 1'b0, "R4 pop");
      run_frame(2, 2, 1'b1, "R6 call");
      run_frame(3, 2, 1'b0, "R8 return");
      run_frame(4, 5, 1'b1, "R7 interrupt");
      run_frame(5, 5, 1'b0, "R8 interrupt return");
      chk("R8 frames restore start", sp, 'h100 | s);
    end

    load_low(0);
    run_frame(0, 1, 1'b1, "R5 push at bottom");
    chk("R5 bottom wraps to top", sp, 'h17F);
    run_frame(1, 1, 1'b0, "R5 pop at top");
    chk("R5 top wraps to bottom", sp, 'h100);

    load_low('h20);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 reset-stack sp", sp, 'h17F);
    chk("R9 no strobe", {mem_wr, mem_rd}, 0);
    exp_lo = 127;

    // Reset-stack held during an interrupt frame must be ignored.
    load_low('h40);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    cmd_op = 3'd6;
    for (int k = 0; k < 5; k++) begin
      chk("R11 not ready in frame", cmd_ready, 0);
      if (k == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R11 held command ignored", sp, 'h13B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule